// File: doc/BRIEF.md
# Periodic Millisecond Interval Timer

This block raises a periodic interrupt whose period software selects in whole milliseconds. A prescaler divides the system clock down to a one-millisecond tick. A period counter counts those ticks and ends each period after (reload + 1) of them. At the end of a period the interrupt output goes high and the next period starts at once, with no action from software.

Software reaches the block through a 32-bit register port with two locations. Writing the reload location stores a new period and starts timing again from zero. Reading the count location returns zero, and that read is also the interrupt acknowledge. The parameter `CYC_PER_MS` sets how many clock cycles make one millisecond.

Top module: `ivt_timer`

## Requirements
- R1: After reset `irq_o` is low and the stored reload value is 0. The first interrupt follows exactly `CYC_PER_MS` clock edges (1 ms) after reset is released.
- R2: After a reload write of value R, `irq_o` first goes high on the clock edge that comes (R+1)*`CYC_PER_MS` edges after the edge that took the write.
- R3: Each period restarts by itself when it expires, so later expiries are (R+1)*`CYC_PER_MS` edges apart. Once high, `irq_o` stays high until it is acknowledged or the reload register is written. Reading the reload location does not clear it.
- R4: A read of the count location (byte offset 0x230) returns 0 in `rdata_o` and drives `irq_o` low after that edge.
- R5: A write to the reload location (byte offset 0x228) drives `irq_o` low after that edge and restarts both the millisecond prescaler and the period count from zero.
- R6: If a period expires on the same edge as an acknowledge read, the expiry wins and `irq_o` stays high.
- R7: An access is accepted only when all four byte enables in `be_i` are 1 (4'hF). Any other access is ignored: it stores nothing, acknowledges nothing, restarts nothing, and returns 0 as read data.
- R8: Read data is registered and appears in `rdata_o` in the cycle after the request. A read of the reload location returns the stored value. Reads of any other offset return 0, and writes to any offset other than the reload location have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the access |
| be_i | input | 4 | Byte enables; must be 4'hF for the access to be accepted |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data, valid the cycle after a read |
| irq_o | output | 1 | Periodic interrupt, level, high until acknowledged |

## Verification
Any fault in the prescaler or in the period counter changes the number of edges between a reload write and the next rising edge of `irq_o`. The bench therefore measures that interval, and the interval between automatic restarts, to the exact edge. Because each measurement is exact, an off-by-one error in either counter shows up within one period.

Faults in the interrupt flag show up on the cycle right after the access that should have affected it. Such faults include a wrong priority between expiry and acknowledge, and a reload write that fails to clear the flag. Faults in the access check or the address decode also show up in that cycle, either as a stored value that changed when it should not have or as nonzero read data.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BE_W   = DATA_W / 8;
  localparam logic [15:0] OFS_RELOAD = 16'h0228;
  localparam logic [15:0] OFS_COUNT  = 16'h0230;

  typedef logic [DATA_W-1:0] word_t;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_WR_RELOAD,
    ACC_RD_RELOAD,
    ACC_RD_COUNT,
    ACC_RD_OTHER
  } acc_e;
endpackage

// File: rtl/ivt_regs.sv
module ivt_regs
  import ivt_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  input  word_t             wdata_i,
  output word_t             rdata_o,
  output word_t             reload_o,
  output logic              restart_o,
  output logic              ack_o
);
  localparam logic [ADDR_W-1:0] A_RELOAD = OFS_RELOAD[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_COUNT  = OFS_COUNT[ADDR_W-1:0];

  acc_e  acc;
  word_t reload_q, rdata_q;
  logic  full_word;

  assign full_word = &be_i;

  always_comb begin
    acc = ACC_NONE;
    if (req_i && full_word) begin
      if (we_i) begin
        if (addr_i == A_RELOAD) acc = ACC_WR_RELOAD;
      end else if (addr_i == A_RELOAD) begin
        acc = ACC_RD_RELOAD;
      end else if (addr_i == A_COUNT) begin
        acc = ACC_RD_COUNT;
      end else begin
        acc = ACC_RD_OTHER;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      rdata_q  <= '0;
    end else begin
      if (acc == ACC_WR_RELOAD) reload_q <= wdata_i;
      rdata_q <= (acc == ACC_RD_RELOAD) ? reload_q : '0;
    end
  end

  assign reload_o  = reload_q;
  assign rdata_o   = rdata_q;
  assign restart_o = (acc == ACC_WR_RELOAD);
  assign ack_o     = (acc == ACC_RD_COUNT);

  // R7: a partial access leaves the stored reload untouched
  a_r7_partial_no_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !full_word) |=> $stable(reload_q));
  // R4: count reads return zero
  a_r4_count_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> (rdata_o == '0));
endmodule

// File: rtl/ivt_prescale.sv
module ivt_prescale #(
  parameter int unsigned CYC_PER_MS = 125000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic ms_tick_o
);
  localparam int unsigned PRE_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_MS - 1);

  logic [PRE_W-1:0] pre_q;
  logic             at_last;

  assign at_last = (pre_q == PRE_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pre_q <= '0;
    else if (restart_i) pre_q <= '0;
    else if (at_last)   pre_q <= '0;
    else                pre_q <= pre_q + 1'b1;
  end

  assign ms_tick_o = at_last && !restart_i;

  generate
    if (CYC_PER_MS > 1) begin : g_spacing
      // R2: ticks are never back to back when a millisecond spans several cycles
      a_r2_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ms_tick_o |=> !ms_tick_o);
    end
  endgenerate
endmodule

// File: rtl/ivt_period.sv
module ivt_period
  import ivt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  restart_i,
  input  logic  ms_tick_i,
  input  word_t reload_i,
  output logic  expire_o
);
  word_t per_q;
  logic  at_end;

  assign at_end   = (per_q == reload_i);
  assign expire_o = ms_tick_i && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        per_q <= '0;
    else if (restart_i) per_q <= '0;
    else if (ms_tick_i) per_q <= at_end ? '0 : per_q + 1'b1;
  end

  // R3: every expiry starts the next period from zero
  a_r3_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> (per_q == '0));
  // R5: restart clears the period count
  a_r5_restart_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (per_q == '0));
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
  import ivt_pkg::*;
#(
  parameter int unsigned CYC_PER_MS = 125000,
  parameter int unsigned ADDR_W     = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  word_t reload;
  logic  restart, ack, ms_tick, expire, irq_q;

  ivt_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .be_i, .wdata_i,
    .rdata_o, .reload_o(reload), .restart_o(restart), .ack_o(ack)
  );

  ivt_prescale #(.CYC_PER_MS(CYC_PER_MS)) u_pre (
    .clk_i, .rst_ni, .restart_i(restart), .ms_tick_o(ms_tick)
  );

  ivt_period u_per (
    .clk_i, .rst_ni, .restart_i(restart), .ms_tick_i(ms_tick),
    .reload_i(reload), .expire_o(expire)
  );

  // priority: restart, then expiry, then acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      irq_q <= 1'b0;
    else if (restart) irq_q <= 1'b0;
    else if (expire)  irq_q <= 1'b1;
    else if (ack)     irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  a_r5_write_clears_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> !irq_o);
  a_r6_expire_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && !restart) |=> irq_o);
  a_r4_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack && !expire && !restart) |=> !irq_o);
  a_r3_irq_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack && !restart) |=> irq_o);
endmodule

// File: tb/ivt_timer_tb_top.sv
module ivt_timer_tb_top;
  localparam int unsigned P = 10;
  localparam logic [11:0] A_RLD = 12'h228;
  localparam logic [11:0] A_CNT = 12'h230;
  localparam int NV = 4;
  localparam logic [31:0] VEC_RLD [NV] = '{32'd0, 32'd1, 32'd3, 32'd6};
  localparam int          VEC_CYC [NV] = '{10, 20, 40, 70};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [3:0]  be = 4'hF;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] rd_cap;

  always #4 clk = ~clk;

  ivt_timer #(.CYC_PER_MS(P), .ADDR_W(12)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one access; samples outputs 1 ns after the accepting edge
  task automatic bus(input bit w, input logic [11:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; be = b;
    @(posedge clk); #1;
    rd_cap = rdata;
    req = 1'b0; we = 1'b0; be = 4'hF;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    forever begin
      @(posedge clk); #1;
      n++;
      if (irq || n > 5000) break;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 check(irq == 1'b0, "R1 irq low in reset", irq, 0);
    check(rdata == 32'd0, "R1 rdata zero in reset", rdata, 0);
    @(negedge clk); rst_n = 1'b1;
    wait_irq(n);
    check(n == P, "R1 first expiry after 1 ms", n, P);
    bus(0, A_RLD, 0, 4'hF);
    check(rd_cap == 32'd0, "R1 reload reset value", rd_cap, 0);

    for (int i = 0; i < NV; i++) begin
      bus(1, A_RLD, VEC_RLD[i], 4'hF);
      check(irq == 1'b0, "R5 reload write lowers irq", irq, 0);
      wait_irq(n);
      check(n == VEC_CYC[i], "R2 first period length", n, VEC_CYC[i]);
      bus(0, A_RLD, 0, 4'hF);
      check(rd_cap == VEC_RLD[i], "R8 reload read back", rd_cap, VEC_RLD[i]);
      check(irq == 1'b1, "R3 irq held over reload read", irq, 1);
      bus(0, A_CNT, 0, 4'hF);
      check(rd_cap == 32'd0, "R4 count reads zero", rd_cap, 0);
      check(irq == 1'b0, "R4 count read acknowledges", irq, 0);
      wait_irq(n);
      check(n == VEC_CYC[i] - 2, "R3 automatic next period", n, VEC_CYC[i] - 2);
    end

    // R5: reload write while irq high restarts from zero
    bus(1, A_RLD, 32'd4, 4'hF);
    check(irq == 1'b0, "R5 write clears pending irq", irq, 0);
    wait_irq(n);
    check(n == 5 * P, "R5 restart period", n, 5 * P);

    // R6: acknowledge on the expiry edge
    bus(1, A_RLD, 32'd0, 4'hF);
    wait_irq(n);
    repeat (P - 1) @(posedge clk);
    bus(0, A_CNT, 0, 4'hF);
    check(irq == 1'b1, "R6 expiry beats acknowledge", irq, 1);
    bus(0, A_CNT, 0, 4'hF);
    check(irq == 1'b0, "R4 plain acknowledge", irq, 0);

    // R7: partial accesses ignored
    bus(1, A_RLD, 32'd5, 4'h3);
    bus(0, A_RLD, 0, 4'hF);
    check(rd_cap == 32'd0, "R7 partial write not stored", rd_cap, 0);
    bus(0, A_RLD, 0, 4'hE);
    check(rd_cap == 32'd0, "R7 partial read returns zero", rd_cap, 0);
    wait_irq(n);
    bus(0, A_CNT, 0, 4'h1);
    check(irq == 1'b1, "R7 partial read no acknowledge", irq, 1);

    // R8: other offsets
    bus(1, A_CNT, 32'hFFFF_FFFF, 4'hF);
    check(irq == 1'b1, "R8 write to count offset ignored", irq, 1);
    bus(0, 12'h100, 0, 4'hF);
    check(rd_cap == 32'd0, "R8 unmapped read zero", rd_cap, 0);
    bus(0, A_RLD, 0, 4'hF);
    check(rd_cap == 32'd0, "R8 reload unchanged by count write", rd_cap, 0);

    finish_run();
  end
endmodule